// File: doc/BRIEF.md
# SIMD Pairwise Vector Adder

This block executes one vector add-pairwise operation for each valid 32-bit instruction word. It decodes the word and sends the two source register numbers to a register file as combinational read addresses. The register file returns both source vectors in the same cycle. The block joins the two sources into one vector of twice the width, with the second source on top. It then adds each pair of neighbouring elements at the selected element width and returns the sums as the destination vector.

The result leaves through a registered write port one cycle after the instruction is presented. The destination register number and a one-cycle valid pulse travel with it. Words that do not match the three-register vector form are flagged as illegal, and so is the reserved width combination. A flagged word causes no register write. The block has no flags output and no trapping logic, and it decodes no other instruction.

Top module: `vpair_add_unit`

## Requirements
- R1: An instruction matches only when bit 31=0, bit 29=0, bits 28:24=01110, bit 21=1, bits 15:11=10111 and bit 10=1 (base word 0x0E20BC00). A non-matching word with in_valid raises `illegal` and leaves `wr_en` low.
- R2: `rn_addr` equals instr[9:5] and `rm_addr` equals instr[20:16], combinationally.
- R3: Field instr[23:22] selects the element width: 00 gives 8 bits, 01 gives 16, 10 gives 32 and 11 gives 64.
- R4: The working vector is {Rm operand, Rn operand}. Result element e is working element 2e plus working element 2e+1, so sums of Rn pairs fill the low half of the destination.
- R5: Each sum wraps modulo 2^esize. No carry crosses an element boundary.
- R6: With instr[30]=0 only bits 63:0 of each source are used, and `wr_data` bits 127:64 are zero.
- R7: instr[30]=0 with instr[23:22]=11 is reserved. It raises `illegal` and does not write.
- R8: One cycle after a cycle with in_valid high, `out_valid` is high and `wr_addr` equals instr[4:0] of that word.
- R9: After reset, and one cycle after any cycle with in_valid low, `out_valid`, `wr_en` and `illegal` are all low.
- R10: `wr_data` is zero whenever `wr_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr | input | 32 | Instruction word |
| in_valid | input | 1 | Instruction present this cycle |
| rn_addr | output | 5 | Read address for first source |
| rm_addr | output | 5 | Read address for second source |
| rn_data | input | 128 | First source vector |
| rm_data | input | 128 | Second source vector |
| wr_en | output | 1 | Destination write strobe |
| wr_addr | output | 5 | Destination register number |
| wr_data | output | 128 | Destination vector |
| out_valid | output | 1 | Result cycle marker |
| illegal | output | 1 | Word rejected |

## Verification
The bench builds the block with its default 128-bit vector length. At that length all four element widths are reachable in both the half-width and full-width modes, and so is the reserved 64-bit half-width case. All-ones and near-overflow operands drive every lane to its wrap boundary at each width. Operands with distinct halves show whether the Rn pair sums land below the Rm pair sums.

// File: rtl/vpa_pkg.sv
package vpa_pkg;

   localparam int unsigned VPA_INSTR_W = 32;
   localparam int unsigned VPA_REG_W   = 5;
   localparam int unsigned VPA_NUM_EW  = 4;
   localparam int unsigned VPA_MIN_EW  = 8;

   // fixed-bit pattern of the three-register pairwise add form
   localparam logic [VPA_INSTR_W-1:0] VPA_FIX_MASK  = 32'hBF20_FC00;
   localparam logic [VPA_INSTR_W-1:0] VPA_FIX_VALUE = 32'h0E20_BC00;

   typedef enum logic [1:0] {
      EW_8  = 2'b00,
      EW_16 = 2'b01,
      EW_32 = 2'b10,
      EW_64 = 2'b11
   } elem_w_e;

   typedef struct packed {
      logic                 hit;
      logic                 full;
      elem_w_e              ew;
      logic [VPA_REG_W-1:0] rd;
      logic [VPA_REG_W-1:0] rn;
      logic [VPA_REG_W-1:0] rm;
      logic                 reserved;
   } vpa_dec_t;

endpackage

// File: rtl/vpa_decode.sv
module vpa_decode
   import vpa_pkg::*;
#(
   parameter int unsigned INSTR_W = 32
) (
   input  logic [INSTR_W-1:0] instr,
   output vpa_dec_t           dec
);

   if (INSTR_W != VPA_INSTR_W) begin : g_bad_width
      $error("vpa_decode: instruction width must be 32");
   end

   always_comb begin
      dec          = '0;
      dec.hit      = ((instr & VPA_FIX_MASK) == VPA_FIX_VALUE);
      dec.full     = instr[30];
      dec.ew       = elem_w_e'(instr[23:22]);
      dec.rm       = instr[20:16];
      dec.rn       = instr[9:5];
      dec.rd       = instr[4:0];
      dec.reserved = !instr[30] && (instr[23:22] == 2'b11);
   end

endmodule

// File: rtl/vpa_join.sv
module vpa_join #(
   parameter int unsigned VLEN = 128
) (
   input  logic              full,
   input  logic [VLEN-1:0]   src_n,
   input  logic [VLEN-1:0]   src_m,
   output logic [2*VLEN-1:0] joined
);

   localparam int unsigned HALF = VLEN / 2;

   if ((VLEN % 2) != 0) begin : g_bad_len
      $error("vpa_join: VLEN must be even");
   end

   // half mode packs both low halves into the low VLEN bits, upper zero
   always_comb begin
      if (full) begin
         joined = {src_m, src_n};
      end else begin
         joined = {{VLEN{1'b0}}, src_m[HALF-1:0], src_n[HALF-1:0]};
      end
   end

endmodule

// File: rtl/vpa_width_sum.sv
module vpa_width_sum #(
   parameter int unsigned VLEN = 128,
   parameter int unsigned EW   = 8
) (
   input  logic [2*VLEN-1:0] joined,
   output logic [VLEN-1:0]   sums
);

   localparam int unsigned LANES = VLEN / EW;

   if ((VLEN % EW) != 0 || EW < 8) begin : g_bad_ew
      $error("vpa_width_sum: EW must divide VLEN and be at least 8");
   end

   for (genvar e = 0; e < LANES; e++) begin : g_lane
      logic [EW-1:0] lo_el;
      logic [EW-1:0] hi_el;
      assign lo_el = joined[(2*e)*EW +: EW];
      assign hi_el = joined[(2*e+1)*EW +: EW];
      // EW-bit sum drops the carry: modulo wrap, nothing crosses lanes
      assign sums[e*EW +: EW] = lo_el + hi_el;
   end

endmodule

// File: rtl/vpair_add_unit.sv
module vpair_add_unit
   import vpa_pkg::*;
#(
   parameter int unsigned VLEN    = 128,
   parameter int unsigned INSTR_W = 32,
   parameter int unsigned REG_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INSTR_W-1:0] instr,
   input  logic               in_valid,
   output logic [REG_W-1:0]   rn_addr,
   output logic [REG_W-1:0]   rm_addr,
   input  logic [VLEN-1:0]    rn_data,
   input  logic [VLEN-1:0]    rm_data,
   output logic               wr_en,
   output logic [REG_W-1:0]   wr_addr,
   output logic [VLEN-1:0]    wr_data,
   output logic               out_valid,
   output logic               illegal
);

   localparam int unsigned HALF = VLEN / 2;

   if (VLEN < 128 || (VLEN % 64) != 0) begin : g_bad_vlen
      $error("vpair_add_unit: VLEN must be a multiple of 64, at least 128");
   end
   if (REG_W != VPA_REG_W) begin : g_bad_regw
      $error("vpair_add_unit: register number width must be 5");
   end

   vpa_dec_t dec;

   vpa_decode #(.INSTR_W(INSTR_W)) u_dec (
      .instr (instr),
      .dec   (dec)
   );

   assign rn_addr = dec.rn;
   assign rm_addr = dec.rm;

   logic [2*VLEN-1:0] joined;

   vpa_join #(.VLEN(VLEN)) u_join (
      .full   (dec.full),
      .src_n  (rn_data),
      .src_m  (rm_data),
      .joined (joined)
   );

   logic [VLEN-1:0] sum_by_ew [VPA_NUM_EW];

   for (genvar w = 0; w < VPA_NUM_EW; w++) begin : g_ew
      vpa_width_sum #(
         .VLEN (VLEN),
         .EW   (VPA_MIN_EW << w)
      ) u_sum (
         .joined (joined),
         .sums   (sum_by_ew[w])
      );
   end

   logic [VLEN-1:0] result;
   logic            accept;

   always_comb begin
      unique case (dec.ew)
         EW_8:    result = sum_by_ew[0];
         EW_16:   result = sum_by_ew[1];
         EW_32:   result = sum_by_ew[2];
         default: result = sum_by_ew[3];
      endcase
   end

   assign accept = dec.hit && !dec.reserved;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en     <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
         out_valid <= 1'b0;
         illegal   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         wr_en     <= in_valid && accept;
         illegal   <= in_valid && !accept;
         wr_addr   <= in_valid ? dec.rd : '0;
         wr_data   <= (in_valid && accept) ? result : '0;
      end
   end

   // R1: a word outside the fixed pattern is rejected
   p_nomatch_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ((instr & VPA_FIX_MASK) != VPA_FIX_VALUE)) |=> (illegal && !wr_en));

   // R6: half mode leaves the upper destination half zero
   p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !instr[30]) |=> (wr_data[VLEN-1:HALF] == '0));

   // R7: reserved width/mode pair never writes
   p_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !instr[30] && (instr[23:22] == 2'b11)) |=> (illegal && !wr_en));

   // R8: result marker and destination one cycle after the word
   p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_valid && (wr_addr == $past(instr[4:0]))));

   // R9: idle cycles produce quiet outputs
   p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !wr_en && !illegal));

   // R10: data bus stays zero without a write
   p_data_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> (wr_data == '0));

endmodule

// File: tb/vpair_add_unit_test.sv
module vpair_add_unit_test;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [31:0]  instr = '0;
   logic         in_valid = 1'b0;
   logic [4:0]   rn_addr, rm_addr;
   logic [127:0] rn_data, rm_data;
   logic         wr_en, out_valid, illegal;
   logic [4:0]   wr_addr;
   logic [127:0] wr_data;

   logic [127:0] regs [32];

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;  // 125 MHz

   assign rn_data = regs[rn_addr];
   assign rm_data = regs[rm_addr];

   vpair_add_unit uut (
      .clk(clk), .rst_n(rst_n), .instr(instr), .in_valid(in_valid),
      .rn_addr(rn_addr), .rm_addr(rm_addr), .rn_data(rn_data), .rm_data(rm_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .out_valid(out_valid), .illegal(illegal)
   );

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   function automatic logic [31:0] mk(bit q, int sz, int rm, int rn, int rd);
      logic [31:0] w;
      w = 32'h0E20BC00;
      w[30] = q;
      w[23:22] = sz[1:0];
      w[20:16] = rm[4:0];
      w[9:5] = rn[4:0];
      w[4:0] = rd[4:0];
      return w;
   endfunction

   function automatic logic [127:0] ref_pair(logic [127:0] n, logic [127:0] m, int sz, bit q);
      logic [255:0] c, mask, a, b;
      logic [127:0] res;
      int esz, dsz;
      esz = 8 << sz;
      dsz = q ? 128 : 64;
      c = q ? {m, n} : {128'b0, m[63:0], n[63:0]};
      mask = (256'd1 << esz) - 1;
      res = '0;
      for (int e = 0; e < dsz / esz; e++) begin
         a = (c >> (2 * e * esz)) & mask;
         b = (c >> ((2 * e + 1) * esz)) & mask;
         res = res | 128'(((a + b) & mask) << (e * esz));
      end
      return res;
   endfunction

   task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // issue one word at a negedge, look at outputs at the following negedge
   task automatic issue(logic [31:0] w);
      @(negedge clk);
      instr = w;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      instr = '0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R9", "out_valid at reset", 128'(out_valid), 128'd0);
      chk("R9", "wr_en at reset", 128'(wr_en), 128'd0);
      chk("R9", "illegal at reset", 128'(illegal), 128'd0);
      chk("R10", "wr_data at reset", wr_data, 128'd0);
   endtask

   task automatic t_addr();
      @(negedge clk);
      instr = mk(1, 0, 19, 6, 0);
      #1;
      chk("R2", "rn_addr", 128'(rn_addr), 128'd6);
      chk("R2", "rm_addr", 128'(rm_addr), 128'd19);
      instr = '0;
   endtask

   task automatic t_op(string req, bit q, int sz, int rm, int rn, int rd);
      logic [127:0] exp;
      exp = ref_pair(regs[rn], regs[rm], sz, q);
      issue(mk(q, sz, rm, rn, rd));
      chk("R8", "out_valid", 128'(out_valid), 128'd1);
      chk("R8", "wr_addr", 128'(wr_addr), 128'(rd));
      chk("R1", "wr_en on legal word", 128'(wr_en), 128'd1);
      chk(req, "wr_data", wr_data, exp);
      if (!q) chk("R6", "upper half", {64'b0, wr_data[127:64]}, 128'd0);
   endtask

   task automatic t_sizes();
      for (int s = 0; s < 4; s++) begin
         t_op("R3", 1'b1, s, 2, 1, 7);   // R3 R4 full width
         if (s != 3) t_op("R6", 1'b0, s, 2, 1, 8);
      end
      // R4: low half of the result comes from the Rn pair sums
      t_op("R4", 1'b1, 2, 4, 3, 9);
   endtask

   task automatic t_wrap();
      for (int s = 0; s < 4; s++) begin
         t_op("R5", 1'b1, s, 10, 10, 11);
         t_op("R5", 1'b1, s, 12, 13, 14);
      end
      chk("R5", "8-bit all-ones pair", ref_pair(regs[10], regs[10], 0, 1'b1),
          {16{8'hFE}});
   endtask

   task automatic t_reject(string req, logic [31:0] w);
      issue(w);
      chk(req, "illegal", 128'(illegal), 128'd1);
      chk(req, "wr_en low", 128'(wr_en), 128'd0);
      chk("R10", "wr_data zero", wr_data, 128'd0);
      chk("R8", "out_valid on rejected", 128'(out_valid), 128'd1);
   endtask

   task automatic t_idle();
      issue(mk(1, 1, 2, 1, 5));
      @(negedge clk);
      chk("R9", "out_valid idle", 128'(out_valid), 128'd0);
      chk("R9", "wr_en idle", 128'(wr_en), 128'd0);
      chk("R9", "illegal idle", 128'(illegal), 128'd0);
      chk("R10", "wr_data idle", wr_data, 128'd0);
   endtask

   initial begin
      for (int i = 0; i < 32; i++) regs[i] = '0;
      regs[1]  = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
      regs[2]  = 128'h01234567_89ABCDEF_FEDCBA98_76543210;
      regs[3]  = 128'h00000000_00000000_00000002_00000001;
      regs[4]  = 128'h00000000_00000000_00000020_00000010;
      regs[10] = {128{1'b1}};
      regs[12] = {16{8'h80}};
      regs[13] = {16{8'h7F}};
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_addr();
      t_sizes();
      t_wrap();
      t_reject("R7", mk(0, 3, 2, 1, 3));
      t_reject("R1", mk(1, 0, 2, 1, 3) | 32'h8000_0000);
      t_reject("R1", mk(1, 0, 2, 1, 3) & ~32'h0000_0400);
      t_reject("R1", mk(1, 0, 2, 1, 3) & ~32'h0020_0000);
      t_idle();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule